// File: doc/BRIEF.md
# DTMF Transceiver Host Register Interface

This block sits between a host processor and the tone generator and tone receiver of a DTMF transceiver. The host reaches it through a 4-bit data bus with an active-low select, separate active-low read and write strobes, and one address line. With the address line low, a write loads the 4-bit code of the tone pair to send and a read returns the code of the last digit received. With the address line high, a write goes to the control registers and a read returns the status nibble.

Two control registers share the single control address. Setting the redirect bit in the primary register sends exactly one following control write to the secondary register. After that write, control writes go back to the primary register. The primary register drives the tone-output enable, the call-progress/DTMF mode and the interrupt enable. The secondary register is exported in full, and its bit 0 turns burst mode off.

The receiver and generator report events on single-cycle pulses. These events set sticky status flags and drive an active-low, open-drain-style interrupt. The end of a status read clears the flags and releases the interrupt.

The host side is synchronous to `clk`:
- A write takes effect on the first rising edge at which `cs_n` and `wr_n` are both sampled low.
- A status read clears the flags on the first rising edge after the read strobe is released.

Top module: `dtmf_host_regs`

## Requirements
- R1: After a synchronous reset, both control registers read as zero, so burst mode is on. All status flags are clear, `irq_n` is high and `bus_oe` is low.
- R2: `bus_oe` is high only while `cs_n` and `rd_n` are both low. While it is high, `bus_out` gives the received digit code when `rsel`=0 and the status nibble when `rsel`=1.
- R3: A write with `rsel`=0 loads `bus_in` into `tx_code` at the edge where the write is first sampled. `tx_load` is then high for exactly the one following cycle.
- R4: A control write with the redirect bit clear loads the primary register. Its bit 0 drives `tone_en`, bit 1 drives `cp_mode` (1 = call progress) and bit 2 drives `irq_en`.
- R5: A primary write with bit 3 set sends only the next control write into the secondary register, which appears on `ctl_b`. That write leaves the primary register unchanged, and later control writes go to the primary register again.
- R6: A `rx_valid` pulse latches `rx_code` as the received digit. It also sets status bit 2 (receive full) and status bit 0 (interrupt occurred).
- R7: While burst mode is on (`ctl_b` bit 0 = 0), a `tx_ready` pulse sets status bit 1 (transmit ready) and bit 0. While burst mode is off, bit 1 is held clear and `tx_ready` does not set bit 0.
- R8: The end of a status read clears status bits 0, 1 and 2, and `irq_n` returns high.
- R9: A set event in the same cycle as the clearing edge of a status read leaves that flag set.
- R10: `irq_n` is low exactly when `irq_en`=1, `cp_mode`=0 and status bit 0 is set.
- R11: Status bit 3 follows the delayed-steering input `steer_in`.
- R12: With `cs_n` high, a write strobe changes no register. A read of the received-digit register clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rsel | input | 1 | Register select: 0 = data, 1 = control/status |
| bus_in | input | 4 | Data from host |
| bus_out | output | 4 | Data to host |
| bus_oe | output | 1 | Drive enable for the shared bus |
| irq_n | output | 1 | Interrupt request, active low (open-drain pull-down) |
| tone_en | output | 1 | Tone output enable to generator |
| cp_mode | output | 1 | 1 = call-progress mode, 0 = DTMF |
| irq_en | output | 1 | Interrupt enable |
| ctl_b | output | 4 | Secondary control register contents |
| tx_code | output | 4 | Tone pair code for the generator |
| tx_load | output | 1 | One-cycle pulse after a new code is written |
| rx_valid | input | 1 | Pulse: receiver has validated a digit |
| rx_code | input | 4 | Code of the validated digit |
| tx_ready | input | 1 | Pulse: burst/pause finished, generator ready |
| steer_in | input | 1 | Delayed-steering level from the receiver |

## Verification
The assertions assume the following about the inputs:
- `rx_valid` and `tx_ready` are clean single-cycle pulses, synchronous to `clk`.
- `rsel` is held steady for the whole of a read strobe.
- Reads and writes never overlap.

The stimulus follows these rules throughout. Every bus strobe is driven on the falling clock edge and held for at least one full cycle. Event pulses are raised for exactly one cycle. The only deliberate overlap is an event placed on the clearing edge of a status read, which exercises the rule that set wins.

// File: rtl/dtmf_regs_pkg.sv
// Package: shared widths and bit positions for the DTMF host register block.
// Assumes a 4-bit host bus; status and control layouts below depend on it.
package dtmf_regs_pkg;
    parameter int unsigned NIB_W = 4;
    typedef logic [NIB_W-1:0] nib_t;

    // Primary control register fields
    localparam int unsigned CRA_TONE = 0;
    localparam int unsigned CRA_CPM  = 1;
    localparam int unsigned CRA_IRQ  = 2;
    localparam int unsigned CRA_SELB = 3;
    localparam int unsigned CRA_W    = CRA_SELB; // stored bits below redirect

    // Secondary control register fields
    localparam int unsigned CRB_BURST_OFF = 0;

    // Status nibble fields
    localparam int unsigned ST_IRQ   = 0;
    localparam int unsigned ST_TXR   = 1;
    localparam int unsigned ST_RXF   = 2;
    localparam int unsigned ST_STEER = 3;
endpackage

// File: rtl/dtmf_bus_strobe.sv
// Module: turns host strobes into single-cycle internal events.
// Assumes strobes are synchronous to clk and rsel is steady during a read.
module dtmf_bus_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic rsel,
    output logic wr_start,
    output logic rd_active,
    output logic stat_rd_done
);
    logic wr_act, wr_q, rd_q, rs_q;

    assign wr_act    = !cs_n && !wr_n;
    assign rd_active = !cs_n && !rd_n;
    assign wr_start  = wr_act && !wr_q;
    assign stat_rd_done = rd_q && !rd_active && rs_q;

    // Remember strobe state and the register addressed by the current read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            rs_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_active;
            if (rd_active) rs_q <= rsel;
        end
    end

    // R3: a write start lasts a single cycle however long the strobe is held.
    a_r3_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
endmodule

// File: rtl/dtmf_ctrl_regs.sv
// Module: two control registers behind one address with a one-shot redirect.
// Assumes wr_ctl is a single-cycle pulse per host control write.
module dtmf_ctrl_regs
    import dtmf_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  nib_t             din,
    output logic [CRA_W-1:0] cra,
    output nib_t             crb
);
    logic to_b;

    // Steer each control write to A or B and track the one-shot redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cra  <= '0;
            crb  <= '0;
            to_b <= 1'b0;
        end else if (wr_ctl) begin
            if (to_b) begin
                crb  <= din;
                to_b <= 1'b0;
            end else begin
                cra  <= din[CRA_W-1:0];
                to_b <= din[CRA_SELB];
            end
        end
    end

    // R5: a redirected write consumes the redirect.
    a_r5_redirect_once: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && to_b |=> !to_b);
    // R5: a redirected write leaves register A alone.
    a_r5_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && to_b |=> $stable(cra));
    // R12: without a control write no control state moves.
    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(cra) && $stable(crb) && $stable(to_b));
endmodule

// File: rtl/dtmf_status_flags.sv
// Module: sticky status flags set by receiver/generator events, cleared by a status read.
// Assumes event inputs are single-cycle pulses; a set beats a clear in the same cycle.
module dtmf_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt,
    input  logic tx_evt,
    input  logic burst_on,
    input  logic rd_clr,
    output logic rx_full,
    output logic tx_rdy,
    output logic irq_flag
);
    logic tx_set;
    assign tx_set = tx_evt && burst_on;

    // Update the three sticky flags with set priority over read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full  <= 1'b0;
            tx_rdy   <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (rx_evt)      rx_full <= 1'b1;
            else if (rd_clr) rx_full <= 1'b0;

            if (!burst_on)   tx_rdy <= 1'b0;
            else if (tx_evt) tx_rdy <= 1'b1;
            else if (rd_clr) tx_rdy <= 1'b0;

            if (rx_evt || tx_set) irq_flag <= 1'b1;
            else if (rd_clr)      irq_flag <= 1'b0;
        end
    end

    // R9: an event on the clearing edge still leaves the flag set.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> rx_full && irq_flag);
    // R8: a status read with no new event empties the receive flag.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && !rx_evt |=> !rx_full);
    // R7: burst mode off keeps transmit-ready low.
    a_r7_burst_off: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_on |=> !tx_rdy);
    // R6: whenever receive full rises the interrupt flag is up too.
    a_r6_irq_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> irq_flag);
endmodule

// File: rtl/dtmf_host_regs.sv
// Module: top of the DTMF host register interface: bus decode, data registers,
// control registers, status flags and interrupt request.
// Assumes host strobes synchronous to clk; bus modelled as in/out/oe.
module dtmf_host_regs
    import dtmf_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic rsel,
    input  logic [3:0] bus_in,
    output logic [3:0] bus_out,
    output logic bus_oe,
    output logic irq_n,
    output logic tone_en,
    output logic cp_mode,
    output logic irq_en,
    output logic [3:0] ctl_b,
    output logic [3:0] tx_code,
    output logic tx_load,
    input  logic rx_valid,
    input  logic [3:0] rx_code,
    input  logic tx_ready,
    input  logic steer_in
);
    logic             wr_start, stat_rd_done;
    logic [CRA_W-1:0] cra;
    nib_t             crb, rx_hold, status;
    logic             burst_on, rx_full, tx_rdy, irq_flag, wr_data;

    dtmf_bus_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rsel(rsel), .wr_start(wr_start), .rd_active(bus_oe),
        .stat_rd_done(stat_rd_done)
    );

    dtmf_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_start && rsel), .din(bus_in),
        .cra(cra), .crb(crb)
    );

    assign burst_on = !crb[CRB_BURST_OFF];

    dtmf_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_valid), .tx_evt(tx_ready),
        .burst_on(burst_on), .rd_clr(stat_rd_done),
        .rx_full(rx_full), .tx_rdy(tx_rdy), .irq_flag(irq_flag)
    );

    assign wr_data = wr_start && !rsel;

    // Latch the transmit code and flag it to the generator for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_code <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= wr_data;
            if (wr_data) tx_code <= bus_in;
        end
    end

    // Hold the code of the last validated received digit.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_hold <= '0;
        else if (rx_valid) rx_hold <= rx_code;
    end

    // Assemble the status nibble and select the read data.
    always_comb begin
        status           = '0;
        status[ST_IRQ]   = irq_flag;
        status[ST_TXR]   = tx_rdy;
        status[ST_RXF]   = rx_full;
        status[ST_STEER] = steer_in;
        bus_out          = rsel ? status : rx_hold;
    end

    assign tone_en = cra[CRA_TONE];
    assign cp_mode = cra[CRA_CPM];
    assign irq_en  = cra[CRA_IRQ];
    assign ctl_b   = crb;
    assign irq_n   = !(irq_en && !cp_mode && irq_flag);

    // R8: a status read without a new event releases the interrupt line.
    a_r8_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_done && !rx_valid && !tx_ready |=> irq_n);
    // R12: the transmit code only moves on a data write.
    a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(tx_code));
    // R3: a data write is announced with a load pulse.
    a_r3_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> tx_load && tx_code == $past(bus_in));
endmodule

// File: tb/dtmf_host_regs_bench.sv
`timescale 1ns/1ps
module dtmf_host_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rsel = 1'b0;
    logic [3:0] bus_in = 4'h0, rx_code = 4'h0;
    logic rx_valid = 1'b0, tx_ready = 1'b0, steer_in = 1'b0;
    logic [3:0] bus_out, ctl_b, tx_code;
    logic bus_oe, irq_n, tone_en, cp_mode, irq_en, tx_load;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dtmf_host_regs u_dtmf_host_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rsel(rsel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .irq_n(irq_n), .tone_en(tone_en), .cp_mode(cp_mode), .irq_en(irq_en),
        .ctl_b(ctl_b), .tx_code(tx_code), .tx_load(tx_load),
        .rx_valid(rx_valid), .rx_code(rx_code), .tx_ready(tx_ready),
        .steer_in(steer_in)
    );

    // Reference model state, advanced behaviourally on each rising edge.
    int  m_a = 0, m_b = 0, m_tx = 0, m_rx = 0;
    bit  m_redir = 0, m_load = 0, m_rxf = 0, m_txr = 0, m_int = 0;
    bit  m_wr_seen = 0, m_rd_seen = 0, m_rd_stat = 0;

    always @(posedge clk) begin
        bit wr_now, rd_now, first_wr, clear_now, burst;
        wr_now    = !cs_n && !wr_n;
        rd_now    = !cs_n && !rd_n;
        first_wr  = wr_now && !m_wr_seen;
        clear_now = m_rd_seen && !rd_now && m_rd_stat;
        burst     = (m_b % 2) == 0;
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_tx = 0; m_rx = 0; m_redir = 0; m_load = 0;
            m_rxf = 0; m_txr = 0; m_int = 0; m_wr_seen = 0; m_rd_seen = 0; m_rd_stat = 0;
        end else begin
            if (rx_valid) m_rxf = 1; else if (clear_now) m_rxf = 0;
            if (!burst) m_txr = 0; else if (tx_ready) m_txr = 1; else if (clear_now) m_txr = 0;
            if (rx_valid || (tx_ready && burst)) m_int = 1; else if (clear_now) m_int = 0;
            if (rx_valid) m_rx = int'(rx_code);
            m_load = first_wr && !rsel;
            if (first_wr && !rsel) m_tx = int'(bus_in);
            if (first_wr && rsel) begin
                if (m_redir) begin m_b = int'(bus_in); m_redir = 0; end
                else begin m_a = int'(bus_in) % 8; m_redir = bus_in[3]; end
            end
            if (rd_now) m_rd_stat = rsel;
            m_wr_seen = wr_now;
            m_rd_seen = rd_now;
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model once per cycle, away from the edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            logic [3:0] st;
            bit oe_exp;
            st = {steer_in, m_rxf, m_txr, m_int};
            oe_exp = !cs_n && !rd_n;
            chk("R2 bus_oe", {3'b0, bus_oe}, {3'b0, oe_exp});
            if (oe_exp) chk("R2 bus_out", bus_out, rsel ? st : 4'(m_rx));
            chk("R10 irq_n", {3'b0, irq_n},
                {3'b0, !((m_a / 4) % 2 == 1 && (m_a / 2) % 2 == 0 && m_int)});
            chk("R4 ctrl_a", {1'b0, irq_en, cp_mode, tone_en}, 4'(m_a));
            chk("R5 ctl_b", ctl_b, 4'(m_b));
            chk("R3 tx_code", tx_code, 4'(m_tx));
            chk("R3 tx_load", {3'b0, tx_load}, {3'b0, m_load});
        end
    end

    task automatic host_write(input logic rs, input logic [3:0] d);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; rsel = rs; bus_in = d;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic host_read(input logic rs, output logic [3:0] d);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; rsel = rs;
        #2 d = bus_out;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rx(input logic [3:0] code);
        @(negedge clk); rx_valid = 1'b1; rx_code = code;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] r;
        repeat (4) @(negedge clk);
        #2;
        // R1: reset state
        chk("R1 irq_n", {3'b0, irq_n}, 4'h1);
        chk("R1 bus_oe", {3'b0, bus_oe}, 4'h0);
        chk("R1 ctrl", {1'b0, irq_en, cp_mode, tone_en}, 4'h0);
        chk("R1 ctl_b", ctl_b, 4'h0);
        @(negedge clk); rst_n = 1'b1;

        // R4: primary fields
        host_write(1'b1, 4'b0101);
        #2 chk("R4 tone/irq", {1'b0, irq_en, cp_mode, tone_en}, 4'b0101);

        // R5: one-shot redirect to B, then back to A
        host_write(1'b1, 4'b1101);
        host_write(1'b1, 4'b0001);
        #2 chk("R5 b written", ctl_b, 4'b0001);
        chk("R5 a untouched", {1'b0, irq_en, cp_mode, tone_en}, 4'b0101);
        host_write(1'b1, 4'b0100);
        #2 chk("R5 a again", {1'b0, irq_en, cp_mode, tone_en}, 4'b0100);
        chk("R5 b kept", ctl_b, 4'b0001);
        host_write(1'b1, 4'b1100);
        host_write(1'b1, 4'b0000);
        #2 chk("R5 burst back on", ctl_b, 4'b0000);

        // R3: transmit code and load pulse
        host_write(1'b0, 4'b1010);
        #2 chk("R3 load pulse", {3'b0, tx_load}, 4'h1);
        chk("R3 code", tx_code, 4'b1010);
        @(negedge clk); #2 chk("R3 load ends", {3'b0, tx_load}, 4'h0);

        // R6, R10, R12, R8: received digit
        pulse_rx(4'b0111);
        #2 chk("R10 irq low", {3'b0, irq_n}, 4'h0);
        host_read(1'b0, r); chk("R2 rx data", r, 4'b0111);
        host_read(1'b1, r); chk("R6 R12 status", r, 4'b0101);
        #2 chk("R8 irq released", {3'b0, irq_n}, 4'h1);
        host_read(1'b1, r); chk("R8 status cleared", r, 4'b0000);

        // R11: steering mirror
        steer_in = 1'b1;
        host_read(1'b1, r); chk("R11 steer", r, 4'b1000);
        steer_in = 1'b0;

        // R7: transmit ready in burst mode
        pulse_tx();
        host_read(1'b1, r); chk("R7 tx ready", r, 4'b0011);
        host_read(1'b1, r); chk("R8 tx cleared", r, 4'b0000);

        // R9: event on the clearing edge
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; rsel = 1'b1;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; rx_valid = 1'b1; rx_code = 4'h3;
        @(negedge clk); rx_valid = 1'b0;
        host_read(1'b1, r); chk("R9 set wins", r, 4'b0101);
        host_read(1'b1, r); chk("R9 then clear", r, 4'b0000);

        // R7: burst off blocks transmit ready
        host_write(1'b1, 4'b1100);
        host_write(1'b1, 4'b0001);
        pulse_tx();
        host_read(1'b1, r); chk("R7 burst off", r, 4'b0000);
        #2 chk("R7 no irq", {3'b0, irq_n}, 4'h1);

        // R12: write with chip deselected
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; rsel = 1'b0; bus_in = 4'b0011;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); #2 chk("R12 tx unchanged", tx_code, 4'b1010);
        @(negedge clk); rd_n = 1'b0; #2 chk("R2 no oe unselected", {3'b0, bus_oe}, 4'h0);
        @(negedge clk); rd_n = 1'b1;

        // R10: call-progress mode keeps irq high
        host_write(1'b1, 4'b0110);
        pulse_rx(4'b1001);
        #2 chk("R10 cp mode", {3'b0, irq_n}, 4'h1);
        host_read(1'b1, r); chk("R6 flags in cp", r, 4'b0101);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule